// File: doc/BRIEF.md
# Single-Pass Bounded Counter

This block counts once through a fixed window of values and then parks. A start pulse loads the lower bound (5 by default) and sets the busy flag. After that the count climbs by one on every rising clock edge. On the edge where it lands on the upper bound (67 by default), busy falls and done rises. The count then stays frozen at the upper bound until another start pulse or a reset arrives.

It suits sequencing jobs where something must run for a fixed number of cycles exactly once per request, with the current step visible on the count output. A start pulse while a pass is running has no effect. A start pulse after completion begins a fresh pass. The width and both bounds are parameters; the lower bound must be strictly below the upper bound, and both must fit in the width.

Top module: `onepass_counter`

## Requirements
- R1: While rst_n is low at a rising edge, the next outputs are count 0, busy 0 and done 0.
- R2: A start_i high at a rising edge while busy is 0 sets count to 5, busy to 1 and done to 0 after that edge.
- R3: While busy is 1, each rising edge raises count by exactly one.
- R4: On the edge where count becomes 67, busy goes to 0 and done goes to 1 in the same cycle.
- R5: With done at 1 and start_i low, count stays at 67 and done stays at 1.
- R6: start_i while busy is 1 is ignored: count keeps incrementing and is not reloaded.
- R7: start_i while done is 1 begins a new pass from 5 and clears done.
- R8: A full pass takes 62 rising edges from the edge that loads 5 to the edge that raises done.
- R9: busy and done are never 1 at the same time.
- R10: After reset, with no start, count holds at 0 and both flags stay at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request, sampled at each rising edge |
| count_o | output | 8 | Current count value |
| busy_o | output | 1 | High while a pass is in progress |
| done_o | output | 1 | High once a pass has reached the upper bound |

## Verification
The assertions watch several properties on every cycle. They check that busy and done are never high together and that a busy cycle always advances the count by one. They check that done only rises with the count at the upper bound, and that a parked counter neither moves nor drops done without a start. Other behaviour only the bench scenarios can show: the exact 62-edge length of a pass, the reload to 5 on a restart after completion, the value of the flags after reset, and the effect of a start that arrives mid-pass.

// File: rtl/onepass_pkg.sv
// Shared types for the single-pass counter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package onepass_pkg;

    // Controller phases: waiting for first start, counting, parked at bound.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_RUN    = 2'd1,
        PH_PARKED = 2'd2
    } phase_t;

endpackage

// File: rtl/onepass_ctrl.sv
// Phase controller for the single-pass counter.
// Decides when the datapath loads the lower bound and when it increments.
// Assumes last_step_i is high in the cycle whose increment reaches the
// upper bound. Reset is synchronous, active low.
module onepass_ctrl
    import onepass_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic last_step_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);

    phase_t phase_q;
    phase_t phase_d;

    // Next-phase and command decode.
    always_comb begin
        phase_d = phase_q;
        load_o  = 1'b0;
        step_o  = 1'b0;
        case (phase_q)
            PH_IDLE, PH_PARKED: begin
                if (start_i) begin
                    load_o  = 1'b1;
                    phase_d = PH_RUN;
                end
            end
            PH_RUN: begin
                step_o = 1'b1;
                if (last_step_i) begin
                    phase_d = PH_PARKED;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    assign busy_o = (phase_q == PH_RUN);
    assign done_o = (phase_q == PH_PARKED);

    // R5
    parked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R6
    run_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !last_step_i) |=> busy_o);

endmodule

// File: rtl/onepass_datapath.sv
// Count register for the single-pass counter.
// Loads LO_VAL on load_i, adds one on step_i, otherwise holds.
// Flags the step that will land on HI_VAL. Assumes LO_VAL < HI_VAL and
// that load_i and step_i are never high together.
module onepass_datapath #(
    parameter int WIDTH  = 8,
    parameter int LO_VAL = 5,
    parameter int HI_VAL = 67
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    output logic [WIDTH-1:0] count_o,
    output logic             last_step_o
);

    localparam logic [WIDTH-1:0] LO_W    = WIDTH'(LO_VAL);
    localparam logic [WIDTH-1:0] PRE_HI  = WIDTH'(HI_VAL - 1);

    logic [WIDTH-1:0] count_q;

    // Count register: reset, load, step or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (load_i) count_q <= LO_W;
        else if (step_i) count_q <= count_q + 1'b1;
    end

    assign count_o     = count_q;
    assign last_step_o = step_i && (count_q == PRE_HI);

    // R3
    step_adds_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (count_q == $past(count_q) + 1'b1));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(count_q));

endmodule

// File: rtl/onepass_counter.sv
// Single-pass bounded counter, top level.
// A start pulse loads LO_VAL; the count then rises each edge until HI_VAL,
// where busy drops and done rises, and the count parks. Starts during a
// pass are ignored. Assumes LO_VAL < HI_VAL < 2**WIDTH. Reset synchronous,
// active low.
module onepass_counter #(
    parameter int WIDTH  = 8,
    parameter int LO_VAL = 5,
    parameter int HI_VAL = 67
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic [WIDTH-1:0] count_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [WIDTH-1:0] HI_W = WIDTH'(HI_VAL);

    logic load_w;
    logic step_w;
    logic last_w;

    onepass_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .last_step_i(last_w),
        .load_o     (load_w),
        .step_o     (step_w),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    onepass_datapath #(
        .WIDTH (WIDTH),
        .LO_VAL(LO_VAL),
        .HI_VAL(HI_VAL)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_w),
        .step_i     (step_w),
        .count_o    (count_o),
        .last_step_o(last_w)
    );

    // R9
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R4
    done_at_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (count_o == HI_W && !busy_o));

    // R5
    parked_at_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (count_o == HI_W));

endmodule

// File: tb/onepass_counter_tb.sv
module onepass_counter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LO = 5;
    localparam int HI = 67;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] count_o;
    logic       busy_o;
    logic       done_o;

    int errors = 0;
    int checks = 0;

    // Bench model state
    int  m_cnt = 0;
    bit  m_busy = 0;
    bit  m_done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    onepass_counter u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .count_o(count_o),
        .busy_o (busy_o),
        .done_o (done_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string pick_tag(bit r, bit s);
        if (!r) return "R1";
        if (s && m_done) return "R7";
        if (s && !m_busy) return "R2";
        if (m_busy && (m_cnt + 1 == HI)) return "R4";
        if (m_busy) return (s ? "R6" : "R3");
        if (m_done) return "R5";
        return "R10";
    endfunction

    // One clock: drive at negedge, model the edge, compare at next negedge.
    task automatic cyc(input bit r, input bit s);
        string tag;
        tag = pick_tag(r, s);
        rst_n = r;
        start_i = s;
        @(posedge clk);
        if (!r) begin
            m_cnt = 0; m_busy = 0; m_done = 0;
        end else if (s && !m_busy) begin
            m_cnt = LO; m_busy = 1; m_done = 0;
        end else if (m_busy) begin
            m_cnt = m_cnt + 1;
            if (m_cnt == HI) begin m_busy = 0; m_done = 1; end
        end
        @(negedge clk);
        chk({tag, " count"}, int'(count_o), m_cnt);
        chk({tag, " busy"}, int'(busy_o), int'(m_busy));
        chk({tag, " done"}, int'(done_o), int'(m_done));
        chk("R9 exclusive", int'(busy_o && done_o), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        int seed;
        int edges;
        seed = $urandom(32'd4242);
        @(negedge clk);
        // R1 reset state
        cyc(0, 0);
        cyc(0, 1);
        // R10 idle hold
        repeat (4) cyc(1, 0);
        // R2 load, then R8 pass length
        cyc(1, 1);
        chk("R2 load value", int'(count_o), LO);
        edges = 0;
        while (!done_o && edges < 200) begin
            cyc(1, 0);
            edges++;
        end
        chk("R8 pass length", edges, HI - LO);
        // R5 parked hold
        repeat (5) cyc(1, 0);
        chk("R5 held count", int'(count_o), HI);
        // R7 restart, R6 start mid-pass ignored
        cyc(1, 1);
        chk("R7 restart value", int'(count_o), LO);
        repeat (10) cyc(1, 0);
        cyc(1, 1);
        chk("R6 no reload", int'(count_o), LO + 11);
        // start on the final step edge: ignored
        while (int'(count_o) != HI - 1) cyc(1, 0);
        cyc(1, 1);
        chk("R4 done on bound", int'(done_o), 1);
        // reset mid-pass
        cyc(1, 1);
        repeat (3) cyc(1, 0);
        cyc(0, 0);
        chk("R1 mid-pass reset", int'(count_o), 0);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            bit r;
            bit s;
            r = ($urandom_range(199) != 0);
            s = ($urandom_range(29) == 0);
            cyc(r, s);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule